// File: doc/BRIEF.md
# Frame-Synchronized Serial Port

This block is a synchronous serial port. Words written into a transmit FIFO leave one per frame on a serial output line. Words arriving on a serial input line are collected into a receive FIFO. The bit clock and the frame-sync pulse come from outside, and the block samples both in its own system clock domain. A frame starts when frame sync is seen high at a bit-clock rising edge after it was low at the previous one. The word then follows, most significant bit first. The output changes on bit-clock falling edges and the input is sampled on rising edges.

Software controls the port through an 8-bit control word and sees its state on status outputs. Layout of the control word: bit 0 transmit reset, bit 1 receive reset, bit 2 transmit enable, bit 3 receive enable, bits 5:4 transmit watermark code, bits 7:6 receive watermark code. An enable bit is only a request, and the side it controls wakes up at the next frame start. A reset acts on the next system clock edge. The transmit and receive request outputs tell a transfer engine when the FIFOs need service, based on a watermark threshold.

Top module: `fsync_serial_port`

## Requirements
- R1: Whenever the transmitter is not shifting a word (disabled, after reset, between words, or during an underrun frame), `sdo` is 1.
- R2: Writing 1 to transmit enable makes `tx_on` rise only at the next frame start at which the transmit FIFO holds at least one word; before that `tx_on` stays 0.
- R3: Writing 1 to receive enable makes `rx_on` rise at the next frame start; no word is captured in frames before that.
- R4: `tx_req` is 1 exactly when `tx_on` is 1 and the transmit FIFO free space (DEPTH minus level) is at or above the transmit threshold.
- R5: `rx_req` is 1 exactly when `rx_on` is 1 and the receive FIFO level is at or above the receive threshold.
- R6: A control write with bit 0 set empties the transmit FIFO, clears the shifter, `tx_busy`, `tx_underrun`, `tx_on` and the transmit enable bit (even when bit 2 is written 1 in the same word), and sets `sdo` to 1, all by the next clock edge.
- R7: Both reset bits are self-clearing: `ctl_rdata` bits 1:0 always read 0, while bits 7:2 read back the stored enables and watermark codes in their write positions.
- R8: A control write with bit 1 set empties the receive FIFO and clears `rx_overrun`, `rx_on` and the receive enable bit by the next clock edge.
- R9: Each frame carries one 16-bit word, MSB first. The first bit appears on the bit-clock falling edge after the frame-start rising edge, and each bit is sampled on the following rising edge. The received word enters the receive FIFO after the sixteenth rising edge.
- R10: If the transmitter is active and its FIFO is empty at a frame start, `sdo` stays 1 for that frame and `tx_underrun` is set until a transmit reset.
- R11: A word completed while the receive FIFO is full is dropped. The level stays at DEPTH and `rx_overrun` is set until a receive reset.
- R12: Watermark code 0, 1, 2, 3 selects a threshold of 1, 4, 8, 12 entries (code times DEPTH/4, with code 0 meaning 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word to write |
| ctl_rdata | output | 8 | Control word readback |
| tx_push | input | 1 | Write a word into the transmit FIFO |
| tx_wdata | input | WIDTH | Word to transmit |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_rdata | output | WIDTH | Head of the receive FIFO |
| sck | input | 1 | Bit clock |
| fsync | input | 1 | Frame sync |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| tx_req | output | 1 | Transmit transfer request |
| rx_req | output | 1 | Receive transfer request |
| tx_on | output | 1 | Transmitter active |
| rx_on | output | 1 | Receiver active |
| tx_busy | output | 1 | A word is loaded in the transmit shifter |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_underrun | output | 1 | Sticky underrun flag |
| rx_overrun | output | 1 | Sticky overrun flag |
| tx_level | output | $clog2(DEPTH)+1 | Transmit FIFO occupancy |
| rx_level | output | $clog2(DEPTH)+1 | Receive FIFO occupancy |

## Verification
The assertions check several rules on every clock. Each enable may only wake its side in the cycle after a frame start. A request is never raised by an inactive side. Both resets land their full set of cleared state one edge later. A push into a full FIFO never moves its level. Bit order, the exact watermark boundaries for each code, underrun and overrun in real frames, and the enable bit being cleared when a reset shares its control word are left to the bench's scenarios. The bench shows these by looping the serial output back to the input and capturing the line itself at each bit-clock rising edge.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   // Control word layout, highest bit first
   typedef struct packed {
      logic [1:0] rx_wm;
      logic [1:0] tx_wm;
      logic       rx_en;
      logic       tx_en;
      logic       rx_rst;
      logic       tx_rst;
   } ctl_word_t;

   // Watermark code to entry threshold: 0 -> 1, n -> n * depth/4
   function automatic int wm_threshold(input int depth, input logic [1:0] code);
      return (code == 2'd0) ? 1 : int'(code) * (depth / 4);
   endfunction

endpackage

// File: rtl/fsp_fifo.sv
module fsp_fifo #(
   parameter  int WIDTH = 16,
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    level,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fsp_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         level <= level + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= wdata;
   end

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (level == CW'(DEPTH)));

endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
   parameter  int WIDTH     = 16,
   parameter  bit MSB_FIRST = 1'b1,
   localparam int BW        = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             enable,
   input  logic             frame_start,
   input  logic             sck_fall,
   input  logic             fifo_empty,
   input  logic [WIDTH-1:0] fifo_data,
   output logic             fifo_pop,
   output logic             sdo,
   output logic             active,
   output logic             busy,
   output logic             underrun
);

   logic [WIDTH-1:0] shreg, sh_next;
   logic [BW-1:0]    bits;
   logic             out_bit, nxt_active;

   if (MSB_FIRST) begin : g_msb
      assign out_bit = shreg[WIDTH-1];
      assign sh_next = {shreg[WIDTH-2:0], 1'b0};
   end else begin : g_lsb
      assign out_bit = shreg[0];
      assign sh_next = {1'b0, shreg[WIDTH-1:1]};
   end

   assign nxt_active = enable && (active || !fifo_empty);
   assign fifo_pop   = frame_start && nxt_active && !fifo_empty && !srst;
   assign busy       = (bits != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; bits <= '0; shreg <= '0; sdo <= 1'b1; underrun <= 1'b0;
      end else if (srst) begin
         active <= 1'b0; bits <= '0; shreg <= '0; sdo <= 1'b1; underrun <= 1'b0;
      end else if (frame_start) begin
         active <= nxt_active;
         if (fifo_pop) begin
            shreg <= fifo_data;
            bits  <= BW'(WIDTH);
         end else begin
            bits <= '0;
            if (nxt_active) underrun <= 1'b1;
         end
      end else if (sck_fall) begin
         if (busy) begin
            sdo   <= out_bit;
            shreg <= sh_next;
            bits  <= bits - BW'(1);
         end else begin
            sdo <= 1'b1;
         end
      end
   end

   // R2
   tx_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(frame_start && enable && !fifo_empty));

endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
   parameter  int WIDTH     = 16,
   parameter  bit MSB_FIRST = 1'b1,
   localparam int BW        = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             enable,
   input  logic             frame_start,
   input  logic             sck_rise,
   input  logic             sdi,
   input  logic             fifo_full,
   output logic             push,
   output logic [WIDTH-1:0] word,
   output logic             active,
   output logic             overrun
);

   logic [WIDTH-1:0] shreg, word_next;
   logic [BW-1:0]    bits;
   logic             done;

   if (MSB_FIRST) begin : g_msb
      assign word_next = {shreg[WIDTH-2:0], sdi};
   end else begin : g_lsb
      assign word_next = {sdi, shreg[WIDTH-1:1]};
   end

   assign done = sck_rise && !frame_start && (bits == BW'(1));
   assign push = done && !fifo_full && !srst;
   assign word = word_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; bits <= '0; shreg <= '0; overrun <= 1'b0;
      end else if (srst) begin
         active <= 1'b0; bits <= '0; shreg <= '0; overrun <= 1'b0;
      end else if (frame_start) begin
         active <= enable;
         bits   <= enable ? BW'(WIDTH) : '0;
      end else if (sck_rise && bits != '0) begin
         shreg <= word_next;
         bits  <= bits - BW'(1);
         if (done && fifo_full) overrun <= 1'b1;
      end
   end

   // R3
   rx_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(frame_start && enable));

endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port #(
   parameter  int WIDTH     = 16,
   parameter  int DEPTH     = 16,
   parameter  bit MSB_FIRST = 1'b1,
   localparam int CW        = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   input  logic             tx_push,
   input  logic [WIDTH-1:0] tx_wdata,
   input  logic             rx_pop,
   output logic [WIDTH-1:0] rx_rdata,
   input  logic             sck,
   input  logic             fsync,
   input  logic             sdi,
   output logic             sdo,
   output logic             tx_req,
   output logic             rx_req,
   output logic             tx_on,
   output logic             rx_on,
   output logic             tx_busy,
   output logic             tx_empty,
   output logic             tx_underrun,
   output logic             rx_overrun,
   output logic [CW-1:0]    tx_level,
   output logic [CW-1:0]    rx_level
);

   if (WIDTH < 2) begin : g_bad_width
      $error("fsync_serial_port: WIDTH must be at least 2");
   end

   fsp_pkg::ctl_word_t wr_f;
   logic       tx_en_q, rx_en_q;
   logic [1:0] tx_wm_q, rx_wm_q;
   logic       tx_rst_hit, rx_rst_hit;
   logic       sck_q, fs_prev, sck_rise, sck_fall, frame_start;
   logic       tx_pop, tx_full_unused, rx_push, rx_full, rx_empty_unused;
   logic [WIDTH-1:0] tx_head, rx_word;
   logic [CW-1:0]    tx_free;

   assign wr_f       = fsp_pkg::ctl_word_t'(ctl_wdata);
   assign tx_rst_hit = ctl_wr && wr_f.tx_rst;
   assign rx_rst_hit = ctl_wr && wr_f.rx_rst;
   assign ctl_rdata  = {rx_wm_q, tx_wm_q, rx_en_q, tx_en_q, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q <= 1'b0; rx_en_q <= 1'b0; tx_wm_q <= '0; rx_wm_q <= '0;
      end else if (ctl_wr) begin
         tx_en_q <= wr_f.tx_en && !wr_f.tx_rst;
         rx_en_q <= wr_f.rx_en && !wr_f.rx_rst;
         tx_wm_q <= wr_f.tx_wm;
         rx_wm_q <= wr_f.rx_wm;
      end
   end

   // Bit clock and frame sync are sampled in the system clock domain
   assign sck_rise    = sck && !sck_q;
   assign sck_fall    = !sck && sck_q;
   assign frame_start = sck_rise && fsync && !fs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0; fs_prev <= 1'b0;
      end else begin
         sck_q <= sck;
         if (sck_rise) fs_prev <= fsync;
      end
   end

   fsp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(tx_rst_hit),
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_head), .level(tx_level), .full(tx_full_unused), .empty(tx_empty));

   fsp_tx #(.WIDTH(WIDTH), .MSB_FIRST(MSB_FIRST)) u_tx (
      .clk(clk), .rst_n(rst_n), .srst(tx_rst_hit), .enable(tx_en_q),
      .frame_start(frame_start), .sck_fall(sck_fall),
      .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop),
      .sdo(sdo), .active(tx_on), .busy(tx_busy), .underrun(tx_underrun));

   fsp_rx #(.WIDTH(WIDTH), .MSB_FIRST(MSB_FIRST)) u_rx (
      .clk(clk), .rst_n(rst_n), .srst(rx_rst_hit), .enable(rx_en_q),
      .frame_start(frame_start), .sck_rise(sck_rise), .sdi(sdi),
      .fifo_full(rx_full), .push(rx_push), .word(rx_word),
      .active(rx_on), .overrun(rx_overrun));

   fsp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rx_rst_hit),
      .push(rx_push), .wdata(rx_word), .pop(rx_pop),
      .rdata(rx_rdata), .level(rx_level), .full(rx_full), .empty(rx_empty_unused));

   assign tx_free = CW'(DEPTH) - tx_level;
   assign tx_req  = tx_on && (int'(tx_free) >= fsp_pkg::wm_threshold(DEPTH, tx_wm_q));
   assign rx_req  = rx_on && (int'(rx_level) >= fsp_pkg::wm_threshold(DEPTH, rx_wm_q));

   // R4
   tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> (tx_on && !tx_full_unused));

   // R5
   rx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |-> (rx_on && !rx_empty_unused));

   // R6
   tx_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tx_rst_hit) |-> (tx_level == '0 && sdo && !tx_on && !tx_busy
                             && !tx_underrun && !ctl_rdata[2]));

   // R8
   rx_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_rst_hit) |-> (rx_level == '0 && !rx_on && !rx_overrun && !ctl_rdata[3]));

endmodule

// File: tb/fsync_serial_port_tb.sv
module fsync_serial_port_tb;

   localparam int WIDTH = 16;
   localparam int DEPTH = 16;
   localparam int CW    = $clog2(DEPTH) + 1;
   localparam int WATCHDOG = 100000;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ctl_wr;
   logic [7:0]       ctl_wdata, ctl_rdata;
   logic             tx_push, rx_pop;
   logic [WIDTH-1:0] tx_wdata, rx_rdata;
   logic             sck, fsync, sdo;
   logic             tx_req, rx_req, tx_on, rx_on, tx_busy, tx_empty;
   logic             tx_underrun, rx_overrun;
   logic [CW-1:0]    tx_level, rx_level;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   fsync_serial_port #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .tx_push(tx_push), .tx_wdata(tx_wdata),
      .rx_pop(rx_pop), .rx_rdata(rx_rdata), .sck(sck), .fsync(fsync),
      .sdi(sdo), .sdo(sdo), .tx_req(tx_req), .rx_req(rx_req),
      .tx_on(tx_on), .rx_on(rx_on), .tx_busy(tx_busy), .tx_empty(tx_empty),
      .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
      .tx_level(tx_level), .rx_level(rx_level));

   // Loopback words: each is pushed, sent in one frame and must come back unchanged
   localparam logic [15:0] WORDS [6] = '{16'hA5C3, 16'h8001, 16'h0000,
                                         16'hFFFE, 16'h1234, 16'h7FFF};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] cw(input bit ten, input bit ren, input bit trst,
                                     input bit rrst, input logic [1:0] twm,
                                     input logic [1:0] rwm);
      return {rwm, twm, ren, ten, rrst, trst};
   endfunction

   task automatic wr_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic push(input logic [15:0] d);
      tx_push = 1'b1; tx_wdata = d;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic sck_cycle(input logic fs, output logic smp);
      sck = 1'b0; fsync = fs;
      repeat (4) @(negedge clk);
      smp = sdo; sck = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // One frame; cap holds the 16 line values seen at the rising edges after frame start
   task automatic run_frame(output logic [15:0] cap);
      logic b;
      cap = '0;
      sck_cycle(1'b1, b);
      for (int i = 0; i < 16; i++) begin
         sck_cycle(1'b0, b);
         cap = {cap[14:0], b};
      end
      repeat (3) sck_cycle(1'b0, b);
   endtask

   initial begin
      logic [15:0] cap;
      int lvl;
      rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; tx_push = 1'b0; tx_wdata = '0;
      rx_pop = 1'b0; sck = 1'b0; fsync = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R1 sdo after reset", sdo, 1);
      chk("R4 tx_req after reset", tx_req, 0);
      chk("R5 rx_req after reset", rx_req, 0);
      chk("R7 ctl_rdata after reset", ctl_rdata, 0);
      chk("R6 tx_empty after reset", tx_empty, 1);

      // R3: frame with nothing enabled captures nothing
      run_frame(cap);
      chk("R1 idle line", cap, 16'hFFFF);
      chk("R3 no capture while disabled", rx_level, 0);

      // Enable both sides; nothing wakes before a frame
      wr_ctl(cw(1, 1, 0, 0, 2'd0, 2'd0));
      chk("R7 R12 readback", ctl_rdata, 8'h0C);
      chk("R2 tx_on before frame", tx_on, 0);
      chk("R3 rx_on before frame", rx_on, 0);

      // Frame with empty transmit FIFO: receiver wakes, transmitter does not
      run_frame(cap);
      chk("R2 tx stays off without data", tx_on, 0);
      chk("R10 no underrun before wake", tx_underrun, 0);
      chk("R3 rx_on after frame", rx_on, 1);
      chk("R1 line high while tx off", cap, 16'hFFFF);
      chk("R3 rx word while tx off", rx_rdata, 16'hFFFF);
      pop();

      // Table of loopback words
      foreach (WORDS[k]) begin
         push(WORDS[k]);
         if (k == 0) chk("R2 tx_on after push, before frame", tx_on, 0);
         run_frame(cap);
         chk("R2 tx_on after frame", tx_on, 1);
         chk("R9 line bit order", cap, WORDS[k]);
         chk("R9 received word", rx_rdata, WORDS[k]);
         chk("R9 one word per frame", rx_level, 1);
         pop();
      end

      // Underrun
      run_frame(cap);
      chk("R10 underrun flag", tx_underrun, 1);
      chk("R10 R1 line high on underrun", cap, 16'hFFFF);
      chk("R10 tx stays on", tx_on, 1);
      pop();

      // Transmit watermark boundaries, levels rising through each code
      lvl = 0;
      for (int code = 3; code >= 0; code--) begin
         int thr;
         thr = (code == 0) ? 1 : code * 4;
         wr_ctl(cw(1, 1, 0, 0, 2'(code), 2'd0));
         while (lvl < DEPTH - thr) begin push(16'h5555); lvl++; end
         chk("R4 R12 tx level", tx_level, lvl);
         chk("R4 R12 tx_req at threshold", tx_req, 1);
         push(16'h5555); lvl++;
         chk("R4 R12 tx_req below threshold", tx_req, 0);
      end

      // Transmit reset shares the word with a transmit enable
      wr_ctl(cw(1, 1, 1, 0, 2'd0, 2'd0));
      chk("R6 tx level cleared", tx_level, 0);
      chk("R6 tx_on cleared", tx_on, 0);
      chk("R6 underrun cleared", tx_underrun, 0);
      chk("R6 sdo high", sdo, 1);
      chk("R6 tx_busy cleared", tx_busy, 0);
      chk("R4 tx_req after reset", tx_req, 0);
      chk("R6 R7 readback", ctl_rdata, 8'h08);
      chk("R6 rx side untouched", rx_on, 1);

      // Receive watermark boundaries
      lvl = 0;
      for (int step = 0; step < 3; step++) begin
         int code, thr;
         code = (step == 0) ? 0 : (step == 1) ? 1 : 3;
         thr  = (code == 0) ? 1 : code * 4;
         wr_ctl(cw(0, 1, 0, 0, 2'd0, 2'(code)));
         while (lvl < thr - 1) begin run_frame(cap); lvl++; end
         chk("R5 R12 rx level", rx_level, lvl);
         chk("R5 R12 rx_req below threshold", rx_req, 0);
         run_frame(cap); lvl++;
         chk("R5 R12 rx_req at threshold", rx_req, 1);
      end
      while (lvl < DEPTH) begin run_frame(cap); lvl++; end
      chk("R11 full level", rx_level, DEPTH);
      chk("R11 no overrun yet", rx_overrun, 0);
      run_frame(cap);
      chk("R11 overrun flag", rx_overrun, 1);
      chk("R11 word dropped", rx_level, DEPTH);

      // Receive reset
      wr_ctl(cw(0, 1, 0, 1, 2'd0, 2'd0));
      chk("R8 rx level cleared", rx_level, 0);
      chk("R8 rx_on cleared", rx_on, 0);
      chk("R8 overrun cleared", rx_overrun, 0);
      chk("R5 rx_req cleared", rx_req, 0);
      chk("R8 R7 readback", ctl_rdata, 8'h00);
      run_frame(cap);
      chk("R8 R3 no capture after reset", rx_level, 0);

      // Both resets with all other bits set
      wr_ctl(8'hFF);
      chk("R7 R12 reset bits read 0", ctl_rdata, 8'hF0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule